// File: doc/BRIEF.md
# Clock Generator Configuration Bank with Nonvolatile Save

This block holds the byte-wide configuration of a clock generator. It has sixteen bytes at the default address width and a small nonvolatile store behind them. A host writes and reads single bytes through a plain port. A separate streaming reader returns a run of consecutive bytes, and the length of that run is itself one of the bank's fields. Byte 0 is a fixed identification word. Reserved bits and the bytes above 6 always read as zero.

Setting the save-start bit copies the live contents into the nonvolatile array. The copy takes a fixed number of cycles, and a busy flag reads high for that whole time. While a save runs, every write is dropped. The stored image never holds a set power-down bit. Once a lock bit has been saved, no further save is accepted. A bank reset (`rst_n`) reloads the live bank from the stored image. A separate power-on reset (`por_n`) returns the store to its factory contents.

Top module: `cfg_bank_nv`

## Requirements
- R1: Byte 0 reads {VARIANT, REV_ID[2:0], 4'h1}, and writes to it have no effect.
- R2: Byte 1 bit 7, byte 5 bits 2:0 and bytes 7 to 15 read 0 whatever value is written to them.
- R3: The writable fields read back the last value written: byte 1 bits 4:0 (bit 4 power-down, bits 3:2 input select, bits 1:0 address bits), bytes 2 to 4 in full, byte 5 bits 7:3 and byte 6 bits 7:1.
- R4: After power-on and bank reset, the bytes read 1:00h, 2:B4h, 3:01h, 4:02h, 5:50h, 6:50h.
- R5: When byte 6 is written with bit 0 set while the bank is idle and unlocked, byte 1 bit 6 (busy) and byte 6 bit 0 read 1 for exactly SAVE_CYCLES cycles after the write edge. After that both read 0.
- R6: Writes to any byte while busy is 1 are ignored.
- R7: A bank reset reloads the contents saved by the most recent save, with byte 1 bit 4 always restored as 0.
- R8: Byte 1 bit 5 (lock) can be set by a write but not cleared by one. Once a save has stored it as 1, a save request leaves busy and byte 6 bit 0 at 0 and leaves the stored image unchanged.
- R9: A block read started at address A returns byte 6 bits 7:1 bytes, from A upward and wrapping modulo the bank size, one per ack. blk_valid then drops.
- R10: A start pulse during an unfinished block read is ignored. A start while the count is 0 returns no bytes.
- R11: Power-on reset restores the factory image even after saves and a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous: sets the nonvolatile array to its factory image |
| rst_n | input | 1 | Bank reset, active low, synchronous: loads the bank from the nonvolatile array |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| blk_start | input | 1 | Starts a block read at blk_addr |
| blk_addr | input | ADDR_W | First address of a block read |
| blk_ack | input | 1 | Consumes the current block byte |
| blk_valid | output | 1 | A block byte is presented |
| blk_data | output | 8 | Current block byte |

## Verification
The bench builds the bank at the default width of sixteen bytes, with SAVE_CYCLES set to 6, VARIANT to 1 and REV_ID to 5. This save length makes it practical to check the busy window cycle by cycle, and to run several complete saves around resets. The small address space allows a sweep that writes all 256 data values to every address, which settles every writable, reserved and read-only bit. A run count of 3 lets block reads start near the top of the bank so that the wrap is exercised.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

   localparam int unsigned CB_STORED = 6;
   localparam int unsigned CB_CTRL   = 1;
   localparam int unsigned CB_CNT    = 6;
   localparam int unsigned BIT_BUSY  = 6;
   localparam int unsigned BIT_LOCK  = 5;
   localparam int unsigned BIT_PWDN  = 4;
   localparam int unsigned CNT_W     = 7;

   typedef logic [7:0] byte_t;
   typedef logic [CB_STORED:1][7:0] image_t;

   // bits a host write may change (lock and save-start handled apart)
   function automatic byte_t wr_mask(input int idx);
      case (idx)
         1:       return 8'h1F;
         2, 3, 4: return 8'hFF;
         5:       return 8'hF8;
         6:       return 8'hFE;
         default: return 8'h00;
      endcase
   endfunction

   // bits kept by the nonvolatile array
   function automatic byte_t nv_mask(input int idx);
      case (idx)
         1:       return 8'h2F;
         2, 3, 4: return 8'hFF;
         5:       return 8'hF8;
         6:       return 8'hFE;
         default: return 8'h00;
      endcase
   endfunction

   function automatic image_t factory_image();
      image_t img;
      img[1] = 8'h00;
      img[2] = 8'hB4;
      img[3] = 8'h01;
      img[4] = 8'h02;
      img[5] = 8'h50;
      img[6] = 8'h50;
      return img;
   endfunction

endpackage

// File: rtl/cfg_nv_store.sv
module cfg_nv_store
   import cfg_bank_pkg::*;
#(
   parameter int unsigned SAVE_CYCLES = 64
) (
   input  logic   clk,
   input  logic   por_n,
   input  logic   save_go,
   input  image_t live,
   output image_t nv,
   output logic   busy,
   output logic   done,
   output logic   locked
);
   localparam int unsigned TMR_W = $clog2(SAVE_CYCLES + 1);

   if (SAVE_CYCLES < 1) begin : g_bad_cycles
      $error("cfg_nv_store: SAVE_CYCLES must be at least 1");
   end

   logic [TMR_W-1:0] tmr;
   image_t           stored;

   for (genvar i = 1; i <= CB_STORED; i++) begin : g_mask
      assign stored[i] = live[i] & nv_mask(i);
   end

   assign done   = busy && (tmr == '0);
   assign locked = nv[CB_CTRL][BIT_LOCK];

   always_ff @(posedge clk) begin
      if (!por_n) begin
         nv   <= factory_image();
         busy <= 1'b0;
         tmr  <= '0;
      end else if (save_go && !busy) begin
         busy <= 1'b1;
         tmr  <= TMR_W'(SAVE_CYCLES - 1);
      end else if (done) begin
         busy <= 1'b0;
         nv   <= stored;
      end else if (busy) begin
         tmr  <= tmr - 1'b1;
      end
   end

   p_nv_only_on_done_r7: assert property (@(posedge clk) disable iff (!por_n)
      !done |=> $stable(nv));
   p_go_when_free_r8: assert property (@(posedge clk) disable iff (!por_n)
      save_go |-> (!locked && !busy));
   p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!por_n)
      done |=> !busy);

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
   import cfg_bank_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter bit          VARIANT = 1'b1,
   parameter logic [2:0]  REV_ID  = 3'd0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [7:0]                  wr_data,
   input  logic [1:0][ADDR_W-1:0]      rd_addr,
   output logic [1:0][7:0]             rd_data,
   input  image_t                      nv_img,
   input  logic                        nv_busy,
   input  logic                        nv_done,
   input  logic                        nv_locked,
   output logic                        save_go,
   output image_t                      live,
   output logic [CNT_W-1:0]            blk_count
);
   localparam byte_t ID_BYTE = {VARIANT, REV_ID, 4'h1};

   image_t bank, nxt;
   logic   write_ok;

   assign write_ok  = wr_en && !nv_busy;
   assign save_go   = write_ok && (wr_addr == ADDR_W'(CB_CNT)) && wr_data[0] && !nv_locked;
   assign live      = bank;
   assign blk_count = bank[CB_CNT][7:1];

   always_comb begin
      nxt = bank;
      for (int i = 1; i <= CB_STORED; i++) begin
         if (write_ok && (wr_addr == ADDR_W'(i))) begin
            nxt[i] = (bank[i] & ~wr_mask(i)) | (wr_data & wr_mask(i));
         end
      end
      if (write_ok && (wr_addr == ADDR_W'(CB_CTRL)) && wr_data[BIT_LOCK]) begin
         nxt[CB_CTRL][BIT_LOCK] = 1'b1;
      end
      if (save_go) begin
         nxt[CB_CNT][0] = 1'b1;
      end else if (nv_done) begin
         nxt[CB_CNT][0] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank <= nv_img;
      end else begin
         bank <= nxt;
      end
   end

   for (genvar p = 0; p < 2; p++) begin : g_rd
      always_comb begin
         rd_data[p] = 8'h00;
         if (rd_addr[p] == '0) begin
            rd_data[p] = ID_BYTE;
         end
         for (int i = 1; i <= CB_STORED; i++) begin
            if (rd_addr[p] == ADDR_W'(i)) begin
               rd_data[p] = bank[i];
            end
         end
         if (rd_addr[p] == ADDR_W'(CB_CTRL)) begin
            rd_data[p][BIT_BUSY] = nv_busy;
         end
      end
   end

   p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bank[CB_CTRL][BIT_LOCK] |=> bank[CB_CTRL][BIT_LOCK]);
   p_frozen_in_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
      nv_busy |=> $stable({bank[5:1], bank[CB_CNT][7:1]}));
   p_no_start_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_locked && !nv_busy) |=> !bank[CB_CNT][0]);

endmodule

// File: rtl/cfg_blk_reader.sv
module cfg_blk_reader
   import cfg_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  count,
   input  logic              ack,
   output logic              valid,
   output logic [ADDR_W-1:0] ptr
);
   logic             active;
   logic [CNT_W-1:0] left;

   assign valid = active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         ptr    <= '0;
         left   <= '0;
      end else if (!active) begin
         if (start && (count != '0)) begin
            active <= 1'b1;
            ptr    <= start_addr;
            left   <= count;
         end
      end else if (ack) begin
         ptr  <= ptr + 1'b1;
         left <= left - 1'b1;
         if (left == CNT_W'(1)) begin
            active <= 1'b0;
         end
      end
   end

   p_hold_without_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !ack) |=> (active && $stable(ptr) && $stable(left)));
   p_last_byte_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ack && left == CNT_W'(1)) |=> !valid);

endmodule

// File: rtl/cfg_bank_nv.sv
module cfg_bank_nv
   import cfg_bank_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SAVE_CYCLES = 64,
   parameter bit          VARIANT     = 1'b1,
   parameter logic [2:0]  REV_ID      = 3'd0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              blk_start,
   input  logic [ADDR_W-1:0] blk_addr,
   input  logic              blk_ack,
   output logic              blk_valid,
   output logic [7:0]        blk_data
);
   if (ADDR_W < 3 || ADDR_W > 8) begin : g_bad_addr
      $error("cfg_bank_nv: ADDR_W must lie between 3 and 8");
   end

   image_t                 nv_img, live;
   logic                   nv_busy, nv_done, nv_locked, save_go;
   logic [CNT_W-1:0]       blk_count;
   logic [ADDR_W-1:0]      blk_ptr;
   logic [1:0][ADDR_W-1:0] rd_addrs;
   logic [1:0][7:0]        rd_datas;

   assign rd_addrs[0] = rd_addr;
   assign rd_addrs[1] = blk_ptr;
   assign rd_data     = rd_datas[0];
   assign blk_data    = rd_datas[1];

   cfg_regfile #(
      .ADDR_W  (ADDR_W),
      .VARIANT (VARIANT),
      .REV_ID  (REV_ID)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addrs),
      .rd_data   (rd_datas),
      .nv_img    (nv_img),
      .nv_busy   (nv_busy),
      .nv_done   (nv_done),
      .nv_locked (nv_locked),
      .save_go   (save_go),
      .live      (live),
      .blk_count (blk_count)
   );

   cfg_nv_store #(
      .SAVE_CYCLES (SAVE_CYCLES)
   ) u_nv (
      .clk     (clk),
      .por_n   (por_n),
      .save_go (save_go),
      .live    (live),
      .nv      (nv_img),
      .busy    (nv_busy),
      .done    (nv_done),
      .locked  (nv_locked)
   );

   cfg_blk_reader #(
      .ADDR_W (ADDR_W)
   ) u_blk (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (blk_start),
      .start_addr (blk_addr),
      .count      (blk_count),
      .ack        (blk_ack),
      .valid      (blk_valid),
      .ptr        (blk_ptr)
   );

endmodule

// File: tb/cfg_bank_nv_tb.sv
module cfg_bank_nv_tb;
   localparam int SAVE = 6;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0, rd_addr = '0, blk_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data, blk_data;
   logic       blk_start = 1'b0, blk_ack = 1'b0, blk_valid;
   int         checks = 0, errors = 0;
   bit         finished = 1'b0;

   always #5 clk = ~clk;

   cfg_bank_nv #(.ADDR_W(4), .SAVE_CYCLES(SAVE), .VARIANT(1'b1), .REV_ID(3'd5)) u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .blk_start(blk_start),
      .blk_addr(blk_addr), .blk_ack(blk_ack), .blk_valid(blk_valid), .blk_data(blk_data)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      rd_addr = 4'(a);
      #1 d = rd_data;
   endtask

   task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
      logic [7:0] d;
      rd(a, d);
      chk(d, exp, tag);
   endtask

   task automatic bank_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic blk_go(input int a);
      @(negedge clk);
      blk_start = 1'b1; blk_addr = 4'(a);
      @(negedge clk);
      blk_start = 1'b0;
   endtask

   task automatic blk_take(input logic [7:0] exp, input string tag);
      chk({7'd0, blk_valid}, 8'h01, {tag, " valid"});
      chk(blk_data, exp, tag);
      blk_ack = 1'b1;
      @(negedge clk);
      blk_ack = 1'b0;
   endtask

   function automatic logic [7:0] sweep_exp(input int a, input logic [7:0] v);
      case (a)
         0:       return 8'hD1;
         1:       return v & 8'h1F;
         2, 3, 4: return v;
         5:       return v & 8'hF8;
         6:       return v & 8'hFE;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check_factory(input string tag);
      rd_chk(1, 8'h00, tag); rd_chk(2, 8'hB4, tag); rd_chk(3, 8'h01, tag);
      rd_chk(4, 8'h02, tag); rd_chk(5, 8'h50, tag); rd_chk(6, 8'h50, tag);
   endtask

   initial begin : main
      logic [7:0] d;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R4 reset image, R1 identification
      check_factory("R4 factory after reset");
      rd_chk(0, 8'hD1, "R1 id byte");
      rd_chk(9, 8'h00, "R2 reserved byte at reset");

      // R1 R2 R3 exhaustive sweep of every address and data value
      for (int a = 0; a < 16; a++) begin
         for (int v = 0; v < 256; v++) begin
            logic [7:0] wv;
            wv = 8'(v);
            if (a == 1) wv[5] = 1'b0;
            if (a == 6) wv[0] = 1'b0;
            wr(a, wv);
            rd_chk(a, sweep_exp(a, wv), (a == 0) ? "R1 id write ignored" :
                   (a > 6) ? "R2 reserved byte" : "R3 field readback with R2 reserved bits");
         end
      end

      // known configuration, count 3
      wr(1, 8'h1B); wr(2, 8'h3C); wr(3, 8'h77); wr(4, 8'h81); wr(5, 8'hA8); wr(6, 8'h06);

      // R5 save window
      wr(6, 8'h07);
      for (int k = 0; k < SAVE; k++) begin
         rd(1, d); chk({7'd0, d[6]}, 8'h01, "R5 busy during save");
         rd_chk(6, 8'h07, "R5 start bit during save");
         if (k == 1) begin
            wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'h00;   // R6 write while busy
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
      rd(1, d); chk({7'd0, d[6]}, 8'h00, "R5 busy clear after save");
      rd_chk(6, 8'h06, "R5 start bit self clears");
      rd_chk(2, 8'h3C, "R6 write during save ignored");

      // R7 reload drops power-down
      bank_reset();
      rd_chk(1, 8'h0B, "R7 reload byte1 power-down cleared");
      rd_chk(2, 8'h3C, "R7 reload byte2"); rd_chk(3, 8'h77, "R7 reload byte3");
      rd_chk(4, 8'h81, "R7 reload byte4"); rd_chk(5, 8'hA8, "R7 reload byte5");
      rd_chk(6, 8'h06, "R7 reload byte6");

      // R9 block read with wrap
      blk_go(14);
      blk_take(8'h00, "R9 block byte 14");
      blk_take(8'h00, "R9 block byte 15");
      blk_take(8'hD1, "R9 block wrap to byte 0");
      chk({7'd0, blk_valid}, 8'h00, "R9 valid drops after count");
      // R10 start ignored mid-read
      blk_go(2);
      blk_take(8'h3C, "R9 block byte 2");
      blk_go(0);
      blk_take(8'h77, "R10 restart ignored byte 3");
      blk_take(8'h81, "R9 block byte 4");
      chk({7'd0, blk_valid}, 8'h00, "R9 valid drops second read");
      // R10 zero count
      wr(6, 8'h00);
      blk_go(1);
      chk({7'd0, blk_valid}, 8'h00, "R10 zero count gives nothing");
      wr(6, 8'h06);

      // R8 lock
      wr(1, 8'h2B);
      wr(6, 8'h07);
      repeat (SAVE + 2) @(negedge clk);
      bank_reset();
      rd_chk(1, 8'h2B, "R8 lock saved");
      wr(2, 8'h11);
      wr(6, 8'h07);
      rd(1, d); chk({7'd0, d[6]}, 8'h00, "R8 locked save no busy");
      rd_chk(6, 8'h06, "R8 locked save start bit stays 0");
      wr(1, 8'h0B);
      rd_chk(1, 8'h2B, "R8 lock not clearable");
      repeat (SAVE + 2) @(negedge clk);
      bank_reset();
      rd_chk(2, 8'h3C, "R8 stored image unchanged");

      // R11 power-on restores factory
      @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check_factory("R11 factory after power-on");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule